// File: doc/BRIEF.md
# Dual Periodic Interrupt Divider

This block counts a clock enable through one free-running binary prescaler and takes two periodic time-outs from taps of that prescaler. The first is the time-base time-out. Its rate is a static strap that picks one of four taps. The second is the real-time-clock time-out. Its rate comes from a 3-bit code written by software, which selects one of eight taps. Each time-out raises its own request flag. The flag stays up until software clears it or the matching vector call is acknowledged.

The block asks for a subroutine call when an enabled flag is pending and the stack has room. Each source has a fixed vector, and the time-base source wins when both are pending. The real-time-clock time-out is also driven out as a one-cycle tick, so that a timer can count it and reach longer periods.

Top module: `tick_irq_divider`

## Requirements
- R1: After reset, `tb_flag`, `rtc_flag`, `rtc_tick` and `call_req` are 0 and `rtc_rate` reads 7.
- R2: With `rtc_rate` = k (written through `rate_wr`/`rate_wdata`), `rtc_tick` pulses high for exactly one cycle every 2^(8+k) cycles in which `fs_en` is high. Code 0 gives the shortest period (256) and code 7 the longest (32768).
- R3: The prescaler advances only in cycles with `fs_en` high. While `fs_en` is low, no tick occurs and no flag is set.
- R4: `rtc_flag` is set in the same cycle that `rtc_tick` is high, and it stays set until it is cleared.
- R5: `tb_flag` is set once every 2^(12+t) `fs_en` cycles, where t = `tb_rate_opt` (0..3).
- R6: A high `tb_clr` or `rtc_clr` clears its flag at the next edge. A time-out in the same cycle overrides the clear.
- R7: `call_req` rises one cycle after an enabled flag is pending with `stack_full` low. It stays low while `stack_full` is high or no pending flag is enabled.
- R8: `call_vec` is 8'h10 for the time-base source and 8'h14 for the real-time-clock source. The time-base source is presented whenever both are pending and enabled.
- R9: `call_ack` high while `call_req` is high clears the flag whose vector is on `call_vec`, and leaves the other flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_en | input | 1 | Prescaler count enable (fS) |
| tb_rate_opt | input | 2 | Static time-base tap select |
| rate_wr | input | 1 | Write strobe for the RTC rate code |
| rate_wdata | input | 3 | RTC rate code to write |
| rtc_rate | output | 3 | Current RTC rate code |
| tb_ien | input | 1 | Time-base interrupt enable |
| rtc_ien | input | 1 | RTC interrupt enable |
| stack_full | input | 1 | High when no call can be taken |
| tb_clr | input | 1 | Software clear of the time-base flag |
| rtc_clr | input | 1 | Software clear of the RTC flag |
| call_ack | input | 1 | Acknowledge of the presented vector call |
| rtc_tick | output | 1 | One-cycle RTC time-out pulse for a timer |
| tb_flag | output | 1 | Time-base request flag |
| rtc_flag | output | 1 | RTC request flag |
| call_req | output | 1 | Vector call request |
| call_vec | output | 8 | Vector address of the request |

## Verification
The assertions assume that `call_ack` comes only while `call_req` is high and lasts a single cycle. The bench pulses it once, only after it has seen the request, and waits several cycles before the next pulse. The single-cycle tick property assumes the shortest RTC period stays far above one cycle. The arbitration checks stop `fs_en` first, so that no new time-out can disturb the flags being examined. `tb_rate_opt` is treated as a strap, and the bench changes it only under reset.

// File: rtl/pidv_pkg.sv
package pidv_pkg;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_TB  = 8'h10;
  localparam logic [VEC_W-1:0] VEC_RTC = 8'h14;
  localparam int SRC_TB  = 0;
  localparam int SRC_RTC = 1;
  localparam int NSRC    = 2;
endpackage

// File: rtl/pidv_prescaler.sv
module pidv_prescaler #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  assign cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pidv_tap.sv
// Rising-edge detector on one prescaler bit picked by sel.
// Tap i watches bit LO-1+i, so its period is 2^(LO+i) steps.
module pidv_tap #(
  parameter int CNT_W = 15,
  parameter int LO    = 8,
  parameter int SEL_W = 3
) (
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             rise
);
  localparam int NTAP = 1 << SEL_W;

  always_comb begin
    rise = 1'b0;
    for (int i = 0; i < NTAP; i++) begin
      if (sel == SEL_W'(i))
        rise = step & cnt_d[LO-1+i] & ~cnt_q[LO-1+i];
    end
  end
endmodule

// File: rtl/pidv_flag.sv
module pidv_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/tick_irq_divider.sv
module tick_irq_divider
  import pidv_pkg::*;
#(
  parameter int RTC_LO       = 8,
  parameter int RTC_SEL_W    = 3,
  parameter int TB_LO        = 12,
  parameter int TB_SEL_W     = 2,
  parameter int RTC_RST_CODE = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fs_en,
  input  logic [TB_SEL_W-1:0]  tb_rate_opt,
  input  logic                 rate_wr,
  input  logic [RTC_SEL_W-1:0] rate_wdata,
  output logic [RTC_SEL_W-1:0] rtc_rate,
  input  logic                 tb_ien,
  input  logic                 rtc_ien,
  input  logic                 stack_full,
  input  logic                 tb_clr,
  input  logic                 rtc_clr,
  input  logic                 call_ack,
  output logic                 rtc_tick,
  output logic                 tb_flag,
  output logic                 rtc_flag,
  output logic                 call_req,
  output logic [VEC_W-1:0]     call_vec
);
  localparam int RTC_TOP = RTC_LO + (1 << RTC_SEL_W) - 1;
  localparam int TB_TOP  = TB_LO + (1 << TB_SEL_W) - 1;
  localparam int CNT_W   = (RTC_TOP > TB_TOP) ? RTC_TOP : TB_TOP;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rtc_rise, tb_rise;
  logic [NSRC-1:0]  set_v, clr_v, flag_v, ien_v, pend_v;
  logic [NSRC-1:0]  ack_v;

  pidv_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .step(fs_en), .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  pidv_tap #(.CNT_W(CNT_W), .LO(RTC_LO), .SEL_W(RTC_SEL_W)) u_rtc_tap (
    .cnt_q(cnt_q), .cnt_d(cnt_d), .step(fs_en), .sel(rtc_rate), .rise(rtc_rise)
  );

  pidv_tap #(.CNT_W(CNT_W), .LO(TB_LO), .SEL_W(TB_SEL_W)) u_tb_tap (
    .cnt_q(cnt_q), .cnt_d(cnt_d), .step(fs_en), .sel(tb_rate_opt), .rise(tb_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rtc_rate <= RTC_SEL_W'(RTC_RST_CODE);
      rtc_tick <= 1'b0;
    end else begin
      if (rate_wr) rtc_rate <= rate_wdata;
      rtc_tick <= rtc_rise;
    end
  end

  // ack targets the source whose vector is currently presented
  assign ack_v[SRC_TB]  = call_ack & call_req & (call_vec == VEC_TB);
  assign ack_v[SRC_RTC] = call_ack & call_req & (call_vec == VEC_RTC);
  assign set_v[SRC_TB]  = tb_rise;
  assign set_v[SRC_RTC] = rtc_rise;
  assign clr_v[SRC_TB]  = tb_clr | ack_v[SRC_TB];
  assign clr_v[SRC_RTC] = rtc_clr | ack_v[SRC_RTC];
  assign ien_v[SRC_TB]  = tb_ien;
  assign ien_v[SRC_RTC] = rtc_ien;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    pidv_flag u_flag (
      .clk(clk), .rst(rst), .set(set_v[s]), .clr(clr_v[s]), .flag(flag_v[s])
    );
    assign pend_v[s] = flag_v[s] & ien_v[s];
  end

  assign tb_flag  = flag_v[SRC_TB];
  assign rtc_flag = flag_v[SRC_RTC];

  always_ff @(posedge clk) begin
    if (rst) begin
      call_req <= 1'b0;
      call_vec <= VEC_TB;
    end else begin
      call_req <= (|pend_v) & ~stack_full;
      call_vec <= pend_v[SRC_TB] ? VEC_TB : VEC_RTC;
    end
  end
endmodule

// File: rtl/pidv_chk.sv
module pidv_chk
  import pidv_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             fs_en,
  input logic             tb_ien,
  input logic             stack_full,
  input logic             rtc_tick,
  input logic             tb_flag,
  input logic             rtc_flag,
  input logic             call_req,
  input logic [VEC_W-1:0] call_vec
);
  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    rtc_tick |=> !rtc_tick);
  // R3
  tick_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!fs_en) |-> !rtc_tick);
  // R4
  tick_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rtc_tick |-> rtc_flag);
  // R7
  stack_block_chk: assert property (@(posedge clk) disable iff (rst)
    stack_full |=> !call_req);
  // R8
  vec_legal_chk: assert property (@(posedge clk) disable iff (rst)
    call_req |-> (call_vec == VEC_TB || call_vec == VEC_RTC));
  // R8
  tb_first_chk: assert property (@(posedge clk) disable iff (rst)
    (call_req && call_vec == VEC_RTC) |-> !($past(tb_flag) && $past(tb_ien)));
endmodule

bind tick_irq_divider pidv_chk u_chk (
  .clk(clk), .rst(rst), .fs_en(fs_en), .tb_ien(tb_ien),
  .stack_full(stack_full), .rtc_tick(rtc_tick), .tb_flag(tb_flag),
  .rtc_flag(rtc_flag), .call_req(call_req), .call_vec(call_vec)
);

// File: tb/tick_irq_divider_test.sv
module tick_irq_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fs_on = 1'b1, fs_half = 1'b0, phase = 1'b0;
  logic       fs_en;
  logic [1:0] tb_rate_opt = 2'd0;
  logic       rate_wr = 1'b0;
  logic [2:0] rate_wdata = 3'd0;
  logic [2:0] rtc_rate;
  logic       tb_ien = 1'b0, rtc_ien = 1'b0, stack_full = 1'b0;
  logic       tb_clr = 1'b0, rtc_clr = 1'b0, call_ack = 1'b0;
  logic       rtc_tick, tb_flag, rtc_flag, call_req;
  logic [7:0] call_vec;
  int total = 0, bad = 0;
  int n;

  localparam int NV = 5;
  localparam int CODES   [NV] = '{0, 1, 2, 3, 7};
  localparam int PERIODS [NV] = '{256, 512, 1024, 2048, 32768};

  always #4 clk = ~clk;
  always @(posedge clk) phase <= #1 ~phase;
  assign fs_en = fs_on & (fs_half ? phase : 1'b1);

  tick_irq_divider uut (
    .clk(clk), .rst(rst), .fs_en(fs_en), .tb_rate_opt(tb_rate_opt),
    .rate_wr(rate_wr), .rate_wdata(rate_wdata), .rtc_rate(rtc_rate),
    .tb_ien(tb_ien), .rtc_ien(rtc_ien), .stack_full(stack_full),
    .tb_clr(tb_clr), .rtc_clr(rtc_clr), .call_ack(call_ack),
    .rtc_tick(rtc_tick), .tb_flag(tb_flag), .rtc_flag(rtc_flag),
    .call_req(call_req), .call_vec(call_vec)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    for (int i = 0; i < k; i++) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
  endtask

  task automatic wait_tick(output int cnt);
    cnt = 0;
    do begin @(posedge clk); #1; cnt++; end while (!rtc_tick && cnt < 70000);
  endtask

  // clears tb_flag on the first edge, then counts edges until it sets again
  task automatic tb_period(output int cnt, output logic cleared);
    cnt = 0;
    tb_clr = 1'b1;
    @(posedge clk); #1; cnt++;
    tb_clr = 1'b0;
    cleared = ~tb_flag;
    while (!tb_flag && cnt < 70000) begin @(posedge clk); #1; cnt++; end
  endtask

  initial begin
    logic clr_ok;
    do_reset();
    // R1
    check("R1 tb_flag", tb_flag, 0);
    check("R1 rtc_flag", rtc_flag, 0);
    check("R1 rtc_tick", rtc_tick, 0);
    check("R1 call_req", call_req, 0);
    check("R1 rtc_rate", rtc_rate, 7);

    // R2 table of rate codes and periods
    for (int v = 0; v < NV; v++) begin
      rate_wdata = 3'(CODES[v]); rate_wr = 1'b1; cyc(1); rate_wr = 1'b0;
      check("R2 rate readback", rtc_rate, CODES[v]);
      wait_tick(n);
      // R4 flag set alongside tick
      check("R4 flag with tick", rtc_flag, 1);
      wait_tick(n);
      check("R2 rtc period", n, PERIODS[v]);
    end

    // R3 half-rate enable doubles the period at code 0
    rate_wdata = 3'd0; rate_wr = 1'b1; cyc(1); rate_wr = 1'b0;
    fs_half = 1'b1;
    wait_tick(n); wait_tick(n);
    check("R3 half-rate period", n, 512);
    fs_half = 1'b0;

    // R5 / R6 time-base periods, software clear
    tb_rate_opt = 2'd0; do_reset();
    while (!tb_flag) cyc(1);
    tb_period(n, clr_ok);
    check("R6 tb_clr clears", clr_ok, 1);
    check("R5 tb period opt0", n, 4096);
    tb_rate_opt = 2'd1; do_reset();
    while (!tb_flag) cyc(1);
    tb_period(n, clr_ok);
    check("R5 tb period opt1", n, 8192);

    // R6 rtc software clear (enable stopped so no new tick)
    rate_wdata = 3'd0; rate_wr = 1'b1; cyc(1); rate_wr = 1'b0;
    while (!(tb_flag && rtc_flag)) cyc(1);
    fs_on = 1'b0; cyc(2);
    rtc_clr = 1'b1; cyc(1); rtc_clr = 1'b0;
    check("R6 rtc_clr clears", rtc_flag, 0);
    check("R6 tb untouched", tb_flag, 1);

    // R3 no tick and no flag while enable is low
    n = 0;
    for (int i = 0; i < 600; i++) begin cyc(1); if (rtc_tick || rtc_flag) n++; end
    check("R3 frozen prescaler", n, 0);

    // restore both flags, then stop the enable for arbitration
    fs_on = 1'b1;
    while (!rtc_flag) cyc(1);
    fs_on = 1'b0; cyc(2);

    // R7 disabled sources give no request
    cyc(3);
    check("R7 disabled no req", call_req, 0);
    tb_ien = 1'b1; rtc_ien = 1'b1; stack_full = 1'b1; cyc(3);
    check("R7 stack full no req", call_req, 0);
    stack_full = 1'b0; cyc(1);
    check("R7 req one cycle later", call_req, 1);
    cyc(2);
    // R8 time-base first
    check("R8 tb vector", call_vec, 8'h10);
    // R9 ack clears tb only
    call_ack = 1'b1; cyc(1); call_ack = 1'b0; cyc(2);
    check("R9 tb cleared", tb_flag, 0);
    check("R9 rtc kept", rtc_flag, 1);
    check("R8 rtc vector", call_vec, 8'h14);
    check("R7 req for rtc", call_req, 1);
    call_ack = 1'b1; cyc(1); call_ack = 1'b0; cyc(2);
    check("R9 rtc cleared", rtc_flag, 0);
    check("R7 no pending no req", call_req, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule